// File: doc/BRIEF.md
# Two-Bank Flash Reset Recovery Sequencer

This block handles a hardware reset for a flash memory with two banks, where one bank can be read while the other is being programmed or erased. An active-low reset input aborts every operation. While that reset is held, the block keeps the data-bus output enable low. When the reset is released, the block times a recovery window for each bank on its own. A bank that was idle when the reset arrived comes back after a short window. A bank whose program/erase engine reported busy at that moment needs a much longer window.

The ready/busy output goes high only once every bank has recovered. A bank that was interrupted in the middle of an operation gets a sticky data-corrupt flag, which marks its target locations for rewriting. The flag stays set until a clear pulse arrives for that bank outside reset. Both windows are parameters counted in clock cycles. A separate power-on reset puts all state into a known condition while the supplies settle. The functional reset is expected to be held low during that time as well.

Top module: `flash_rst_seq`

## Requirements
- R1: On every clock edge at which `hw_rst_n` is sampled low, all `bank_ok` bits and `rdy_busy` are cleared. They are low from the next cycle until recovery ends.
- R2: `dq_oe` is low whenever `hw_rst_n` is low. Otherwise it equals `rd_en` AND `bank_ok[rd_bank]`, with no clock delay.
- R3: While `hw_rst_n` is held low, `bank_busy` and `clr_corrupt` have no effect, except at the assertion edge. The assertion edge is the first edge sampled low after an edge sampled high, or after power-on reset. Only there is `bank_busy` captured.
- R4: A bank whose recovery need is short gets `bank_ok` high after exactly SHORT_CYC consecutive edges sampled with `hw_rst_n` high.
- R5: A bank whose `bank_busy` bit was 1 at the assertion edge needs LONG_CYC such edges. The other bank is not delayed by this.
- R6: `rdy_busy` is high only when every bank's `bank_ok` is high.
- R7: `data_bad[b]` is set at an assertion edge when `bank_busy[b]` is 1. It stays set until an edge at which `hw_rst_n` is high and `clr_corrupt[b]` is 1. At that edge it clears.
- R8: When reset is asserted again before a bank has recovered, that bank's count restarts from zero. Its long-recovery need is the OR of the earlier need and the newly captured busy bit.
- R9: While `por_n` is low, `bank_ok`, `rdy_busy` and `data_bad` are all 0, and no long-recovery need is pending. After release, each bank recovers with the short window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_n | input | 1 | Functional hardware reset, active low, sampled on clk |
| bank_busy | input | NBANK | Program/erase engine busy, one bit per bank |
| clr_corrupt | input | NBANK | Pulse that clears a bank's corrupt flag |
| rd_en | input | 1 | Host read request (output enable request) |
| rd_bank | input | BW | Bank addressed by the read |
| dq_oe | output | 1 | Data-bus output enable |
| rdy_busy | output | 1 | Ready (1) / busy (0) status |
| bank_ok | output | NBANK | Bank may be accessed |
| data_bad | output | NBANK | Bank holds locations corrupted by an interrupted operation |

## Verification
The assertions assume that `por_n` is low at the first clock edge and is released only once. They also assume that `hw_rst_n`, `bank_busy`, `clr_corrupt` and the read inputs are synchronous to `clk`, and that LONG_CYC is not smaller than SHORT_CYC. The stimulus changes every input only on the falling clock edge. It releases power-on reset once, while `hw_rst_n` is still held low. It uses a short window of 6 and a long window of 30. With these values, a second reset that arrives partway through a long recovery falls clearly inside that recovery.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  // Number of recovery edges a bank needs, picked by its busy history.
  function automatic int unsigned recov_cycles(input logic need_long,
                                               input int unsigned short_c,
                                               input int unsigned long_c);
    return need_long ? long_c : short_c;
  endfunction

  // Width of a counter that must reach 'n'.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rst_edge_det.sv
module rst_edge_det (
  input  logic clk,
  input  logic por_n,
  input  logic hw_rst_n,
  output logic rst_fall
);
  logic hi_q;

  // The power-on state counts as "previously high", so a reset that is held
  // through power-up still produces one assertion edge.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hi_q <= 1'b1;
    else        hi_q <= hw_rst_n;
  end

  assign rst_fall = hi_q & ~hw_rst_n;
endmodule

// File: rtl/bank_recovery.sv
module bank_recovery
  import flash_rst_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 125,
  parameter int unsigned LONG_CYC  = 4000
) (
  input  logic clk,
  input  logic por_n,
  input  logic hw_rst_n,
  input  logic rst_fall,
  input  logic busy_in,
  input  logic clr_in,
  output logic ready,
  output logic corrupt,
  output logic expire
);
  localparam int unsigned CW = cnt_width(LONG_CYC);

  logic [CW-1:0] cnt;
  logic          need_long;
  logic          ready_q;
  logic          corrupt_q;

  assign expire = ~ready_q & hw_rst_n &
                  (32'(cnt) == recov_cycles(need_long, SHORT_CYC, LONG_CYC) - 1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt       <= '0;
      need_long <= 1'b0;
      ready_q   <= 1'b0;
      corrupt_q <= 1'b0;
    end else if (!hw_rst_n) begin
      cnt     <= '0;
      ready_q <= 1'b0;
      if (rst_fall) begin
        need_long <= need_long | busy_in;
        corrupt_q <= corrupt_q | busy_in;
      end
    end else begin
      if (expire) begin
        ready_q   <= 1'b1;
        need_long <= 1'b0;
        cnt       <= '0;
      end else if (!ready_q) begin
        cnt <= cnt + 1'b1;
      end
      if (clr_in) corrupt_q <= 1'b0;
    end
  end

  assign ready   = ready_q;
  assign corrupt = corrupt_q;
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int unsigned NBANK     = 2,
  parameter int unsigned SHORT_CYC = 125,
  parameter int unsigned LONG_CYC  = 4000,
  localparam int unsigned BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             hw_rst_n,
  input  logic [NBANK-1:0] bank_busy,
  input  logic [NBANK-1:0] clr_corrupt,
  input  logic             rd_en,
  input  logic [BW-1:0]    rd_bank,
  output logic             dq_oe,
  output logic             rdy_busy,
  output logic [NBANK-1:0] bank_ok,
  output logic [NBANK-1:0] data_bad
);
  logic             rst_fall;
  logic [NBANK-1:0] expire;

  initial begin
    if (SHORT_CYC < 1 || LONG_CYC < SHORT_CYC)
      $error("flash_rst_seq: need 1 <= SHORT_CYC <= LONG_CYC");
  end

  rst_edge_det u_edge (
    .clk      (clk),
    .por_n    (por_n),
    .hw_rst_n (hw_rst_n),
    .rst_fall (rst_fall)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_recovery #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
    ) u_rec (
      .clk      (clk),
      .por_n    (por_n),
      .hw_rst_n (hw_rst_n),
      .rst_fall (rst_fall),
      .busy_in  (bank_busy[b]),
      .clr_in   (clr_corrupt[b]),
      .ready    (bank_ok[b]),
      .corrupt  (data_bad[b]),
      .expire   (expire[b])
    );
  end

  assign rdy_busy = &bank_ok;
  assign dq_oe    = hw_rst_n & rd_en & bank_ok[rd_bank];
endmodule

// File: rtl/flash_rst_seq_chk.sv
module flash_rst_seq_chk #(
  parameter int unsigned NBANK = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic             hw_rst_n,
  input logic [NBANK-1:0] busy,
  input logic [NBANK-1:0] clr,
  input logic             dq_oe,
  input logic             rdy,
  input logic [NBANK-1:0] ok,
  input logic [NBANK-1:0] bad,
  input logic             fall
);
  // R2
  dq_tristate_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hw_rst_n |-> !dq_oe);

  // R1
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hw_rst_n |=> !rdy);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    // R7
    bad_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (fall && busy[b]) |=> bad[b]);

    // R7
    bad_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (bad[b] && !(hw_rst_n && clr[b])) |=> bad[b]);

    // R3
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!fall && !bad[b]) |=> !bad[b]);

    // R4
    ok_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ok[b]) |-> $past(hw_rst_n));
  end
endmodule

bind flash_rst_seq flash_rst_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .hw_rst_n (hw_rst_n),
  .busy     (bank_busy),
  .clr      (clr_corrupt),
  .dq_oe    (dq_oe),
  .rdy      (rdy_busy),
  .ok       (bank_ok),
  .bad      (data_bad),
  .fall     (u_edge.rst_fall)
);

// File: tb/sim_flash_rst_seq.sv
module sim_flash_rst_seq;
  localparam int NB = 2;
  localparam int S  = 6;
  localparam int L  = 30;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          hw_rst_n = 1'b0;
  logic [NB-1:0] bank_busy = '0;
  logic [NB-1:0] clr_corrupt = '0;
  logic          rd_en = 1'b0;
  logic [0:0]    rd_bank = 1'b0;
  logic          dq_oe, rdy_busy;
  logic [NB-1:0] bank_ok, data_bad;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pat = 0;

  // reference model state
  int m_run [NB];
  bit m_long[NB];
  bit m_bad [NB];
  bit m_prev_hi = 1;

  always #2 clk = ~clk;   // 250 MHz

  flash_rst_seq #(.NBANK(NB), .SHORT_CYC(S), .LONG_CYC(L)) u0 (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .bank_busy(bank_busy),
    .clr_corrupt(clr_corrupt), .rd_en(rd_en), .rd_bank(rd_bank),
    .dq_oe(dq_oe), .rdy_busy(rdy_busy), .bank_ok(bank_ok), .data_bad(data_bad)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_ok(input int b);
    return m_run[b] >= (m_long[b] ? L : S);
  endfunction

  // model update and comparison, once per clock
  always @(posedge clk) begin
    if (!por_n) begin
      for (int b = 0; b < NB; b++) begin m_run[b] = 0; m_long[b] = 0; m_bad[b] = 0; end
      m_prev_hi = 1;
    end else if (!hw_rst_n) begin
      for (int b = 0; b < NB; b++) begin
        if (m_prev_hi) begin
          m_long[b] = m_long[b] | bank_busy[b];
          m_bad[b]  = m_bad[b]  | bank_busy[b];
        end
        m_run[b] = 0;
      end
      m_prev_hi = 0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (!m_ok(b)) begin
          m_run[b]++;
          if (m_ok(b)) m_long[b] = 0;
        end
        if (clr_corrupt[b]) m_bad[b] = 0;
      end
      m_prev_hi = 1;
    end
    #1;
    if (!done) begin
      bit all;
      all = 1;
      for (int b = 0; b < NB; b++) begin
        chk($sformatf("R4/R5 bank_ok[%0d]", b), int'(bank_ok[b]), int'(m_ok(b)));
        chk($sformatf("R7 data_bad[%0d]", b), int'(data_bad[b]), int'(m_bad[b]));
        all &= m_ok(b);
      end
      chk("R6 rdy_busy", int'(rdy_busy), int'(all));
      chk("R2 dq_oe", int'(dq_oe), int'(hw_rst_n & rd_en & m_ok(int'(rd_bank))));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pat++;
      rd_en   = (pat % 3) != 0;
      rd_bank = 1'(pat / 2);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: power-on state
    step(3);
    chk("R9 bank_ok after power-on", int'(bank_ok), 0);
    chk("R9 data_bad after power-on", int'(data_bad), 0);
    chk("R9 rdy_busy after power-on", int'(rdy_busy), 0);
    por_n = 1'b1;
    step(3);
    hw_rst_n = 1'b1;
    step(S - 1);
    chk("R4 not ready one edge early", int'(bank_ok), 0);
    step(1);
    chk("R4 both banks ready after short window", int'(bank_ok), 3);
    step(4);

    // R5/R7: bank 0 busy at the assertion edge, bank 1 idle
    bank_busy = 2'b01;
    hw_rst_n  = 1'b0;
    step(1);
    chk("R1 bank_ok cleared in reset", int'(bank_ok), 0);
    chk("R2 dq_oe low in reset", int'(dq_oe), 0);
    bank_busy   = 2'b10;   // R3: ignored while held
    clr_corrupt = 2'b11;
    step(2);
    chk("R3 late busy does not corrupt bank 1", int'(data_bad[1]), 0);
    chk("R3 clear ignored in reset, bank 0", int'(data_bad[0]), 1);
    bank_busy   = 2'b00;
    clr_corrupt = 2'b00;
    hw_rst_n    = 1'b1;
    step(S);
    chk("R5 idle bank 1 ready", int'(bank_ok[1]), 1);
    chk("R5 busy bank 0 still recovering", int'(bank_ok[0]), 0);
    chk("R6 rdy_busy low", int'(rdy_busy), 0);
    step(L - S);
    chk("R5 bank 0 ready after long window", int'(bank_ok[0]), 1);
    chk("R7 bank 0 flagged corrupt", int'(data_bad[0]), 1);
    step(3);
    clr_corrupt = 2'b01;
    step(1);
    clr_corrupt = 2'b00;
    chk("R7 clear pulse clears bank 0", int'(data_bad[0]), 0);
    step(2);

    // R8: bank 1 busy, then reassert mid-recovery with no busy
    bank_busy = 2'b10;
    hw_rst_n  = 1'b0;
    step(2);
    bank_busy = 2'b00;
    hw_rst_n  = 1'b1;
    step(10);
    hw_rst_n = 1'b0;
    step(2);
    hw_rst_n = 1'b1;
    step(S + 1);
    chk("R8 bank 0 short after reassert", int'(bank_ok[0]), 1);
    chk("R8 bank 1 keeps long need", int'(bank_ok[1]), 0);
    step(L - S - 2);
    chk("R8 bank 1 count restarted", int'(bank_ok[1]), 0);
    step(1);
    chk("R8 bank 1 ready after full long window", int'(bank_ok[1]), 1);
    chk("R7 bank 1 corrupt kept", int'(data_bad[1]), 1);
    step(5);
    finish_run();
  end
endmodule